// File: doc/BRIEF.md
# Punched-Card Reader Emulator with Program-Load Sequencer

This block stands in for a punched-card reader attached to the I/O channel of a 16-bit minicomputer. The channel side issues three kinds of command: sense, read and program load. A sense returns a 16-bit device status word one cycle later and can also clear a pending interrupt. A read pulls 80 card columns of 12 bits from a host-side column stream and stores each column as one word in core memory, starting at an address given with the command. The words go out through a valid/ready memory-write port. When the last column has been written, the block raises the read-complete interrupt.

A program-load command stores one card from core word 0 upward, using the packed load format. It raises no interrupt. Once the last word is written, it drives the immediate-stop, reset and start console lines one after another. The reset leaves the instruction address at zero, so execution begins with the first word of the card.

Top module: `card_reader_emu`

## Requirements
- R1: After reset, `irq`, `rsp_valid`, `col_ready`, `mem_valid` and the three console lines are all low.
- R2: A sense command makes `rsp_valid` high in the next cycle. `rsp_dsw` then carries the status sampled in the command cycle. Status bit n sits at `rsp_dsw[15-n]`: bit 0 is interrupt pending, bit 3 is last card, bit 14 is busy and bit 15 is busy-or-not-ready. All other bits are zero.
- R3: A read writes column i to address base+i, for i from 0 to 79, as `{column, 4'b0000}`. A write is held stable until `mem_ready` accepts it. No further column is taken while a write is outstanding.
- R4: Bit 14 (busy) clears at the same clock edge at which `irq` rises, when a read completes. After that, if no card is ready, the status shows bit 15 set and bit 14 clear.
- R5: Bit 15 equals busy OR (NOT `card_ready`).
- R6: Bit 3 (last card) holds the `col_last` value presented with column 79 of the most recently completed card.
- R7: A sense with `cmd_clr_irq` set clears `irq`. Busy, busy-or-not-ready and last-card are unchanged by it.
- R8: A read or load command is ignored while busy, while the console sequence runs, or while `card_ready` is low. Busy stays set, and the ignored command writes nothing to memory.
- R9: A program load writes column i to address i as `{col[11:8], 4'b0000, col[7:0]}`. It does not raise `irq`.
- R10: After a load completes, `con_stop`, `con_reset` and `con_start` pulse once each, in that order. Each pulse is high for `cfg_pulse_len` cycles, with 0 treated as 1. The gap between pulses is 4 cycles. The sequence runs exactly once per load.
- R11: A read completion and a clearing sense can occur in the same cycle. In that case `irq` is left set. The sensed word shows the state before completion: bit 14 set and bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Channel command strobe |
| cmd_op | input | 2 | 0 sense, 1 read, 2 program load |
| cmd_clr_irq | input | 1 | With a sense: clear the pending interrupt |
| cmd_addr | input | 16 | Read start address |
| card_ready | input | 1 | A card is present in the host-side hopper |
| cfg_pulse_len | input | 8 | Console pulse width in cycles |
| rsp_valid | output | 1 | Sense response strobe |
| rsp_dsw | output | 16 | Device status word |
| irq | output | 1 | Read-complete interrupt, level |
| col_valid | input | 1 | Column available from host |
| col_data | input | 12 | Column rows |
| col_last | input | 1 | Card is the last card (meaningful on column 79) |
| col_ready | output | 1 | Column accepted on this edge if valid |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 16 | Core word address |
| mem_data | output | 16 | Word to store |
| mem_ready | input | 1 | Memory accepts the write |
| con_stop | output | 1 | Immediate-stop console line |
| con_reset | output | 1 | Reset console line |
| con_start | output | 1 | Start console line |

## Verification
The completion of the final memory write and a sense with the interrupt-clear flag can fall on the same clock edge. The bench provokes this by holding `mem_ready` low once the write to base+79 is pending. In one cycle it then raises `mem_ready` and issues the clearing sense together. It judges the result in three ways: the sensed word must still show busy with no interrupt, `irq` must stay high, and a sense in the following cycle must show busy gone and the interrupt pending.

// File: rtl/crd_pkg.sv
package crd_pkg;

    localparam logic [1:0] OP_SENSE = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_LOAD  = 2'd2;

    typedef enum logic [1:0] {
        X_IDLE  = 2'd0,
        X_WAIT  = 2'd1,
        X_WRITE = 2'd2
    } xfer_st_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PULSE = 2'd1,
        S_GAP   = 2'd2
    } seq_st_e;

    // status word bit numbers, bit 0 is the most significant
    localparam int SW_IRQ  = 0;
    localparam int SW_LAST = 3;
    localparam int SW_BUSY = 14;
    localparam int SW_BNR  = 15;

endpackage

// File: rtl/crd_xfer.sv
module crd_xfer
    import crd_pkg::*;
#(
    parameter int COLS    = 80,
    parameter int COL_W   = 12,
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int LOAD_HI = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              col_valid,
    input  logic [COL_W-1:0]  col_data,
    input  logic              col_last,
    output logic              col_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              done_load,
    output logic              done_last
);
    localparam int CNT_W = $clog2(COLS);
    localparam int PAD_W = WORD_W - COL_W;

    typedef struct packed {
        xfer_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              load;
        logic              last;
    } xfer_t;

    xfer_t q, d;

    function automatic logic [WORD_W-1:0] norm_fmt(input logic [COL_W-1:0] c);
        return {c, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] load_fmt(input logic [COL_W-1:0] c);
        return {c[COL_W-1 -: LOAD_HI], {PAD_W{1'b0}}, c[COL_W-LOAD_HI-1:0]};
    endfunction

    always_comb begin
        d    = q;
        done = 1'b0;
        unique case (q.st)
            X_IDLE: begin
                if (start) begin
                    d.st   = X_WAIT;
                    d.cnt  = '0;
                    d.addr = start_load ? '0 : start_addr;
                    d.load = start_load;
                    d.last = 1'b0;
                end
            end
            X_WAIT: begin
                if (col_valid) begin
                    d.data = q.load ? load_fmt(col_data) : norm_fmt(col_data);
                    d.last = col_last;
                    d.st   = X_WRITE;
                end
            end
            X_WRITE: begin
                if (mem_ready) begin
                    if (q.cnt == CNT_W'(COLS - 1)) begin
                        d.st = X_IDLE;
                        done = 1'b1;
                    end else begin
                        d.cnt  = q.cnt + 1'b1;
                        d.addr = q.addr + 1'b1;
                        d.st   = X_WAIT;
                    end
                end
            end
            default: d.st = X_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: X_IDLE, cnt: '0, addr: '0, data: '0, load: 1'b0, last: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign col_ready = (q.st == X_WAIT);
    assign mem_valid = (q.st == X_WRITE);
    assign mem_addr  = q.addr;
    assign mem_data  = q.data;
    assign busy      = (q.st != X_IDLE);
    assign done_load = q.load;
    assign done_last = q.last;

endmodule

// File: rtl/crd_seq.sv
module crd_seq
    import crd_pkg::*;
#(
    parameter int PLEN_W  = 8,
    parameter int GAP_CYC = 4,
    parameter int N_STEP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [PLEN_W-1:0] pulse_len,
    output logic              active,
    output logic [N_STEP-1:0] lines
);
    localparam int GAP_W  = $clog2(GAP_CYC + 1);
    localparam int CNT_W  = (PLEN_W > GAP_W) ? PLEN_W : GAP_W;
    localparam int STEP_W = $clog2(N_STEP);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (trig) begin
                    d.st   = S_PULSE;
                    d.step = '0;
                    d.cnt  = '0;
                    d.len  = (pulse_len == '0) ? CNT_W'(1) : CNT_W'(pulse_len);
                end
            end
            S_PULSE: begin
                if (q.cnt == q.len - 1'b1) begin
                    d.cnt = '0;
                    d.st  = (q.step == STEP_W'(N_STEP - 1)) ? S_IDLE : S_GAP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_GAP: begin
                if (q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    d.cnt  = '0;
                    d.step = q.step + 1'b1;
                    d.st   = S_PULSE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, step: '0, cnt: '0, len: '0};
        end else begin
            q <= d;
        end
    end

    assign active = (q.st != S_IDLE);

    for (genvar k = 0; k < N_STEP; k++) begin : g_line
        assign lines[k] = (q.st == S_PULSE) && (q.step == STEP_W'(k));
    end

endmodule

// File: rtl/crd_status.sv
module crd_status
    import crd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sense,
    input  logic              clr_irq,
    input  logic              done,
    input  logic              done_load,
    input  logic              done_last,
    input  logic              busy,
    input  logic              card_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_dsw,
    output logic              irq
);
    typedef struct packed {
        logic              irq;
        logic              last;
        logic              rv;
        logic [WORD_W-1:0] rw;
    } stat_t;

    stat_t q, d;
    logic [WORD_W-1:0] word_now;

    always_comb begin
        word_now                       = '0;
        word_now[WORD_W - 1 - SW_IRQ]  = q.irq;
        word_now[WORD_W - 1 - SW_LAST] = q.last;
        word_now[WORD_W - 1 - SW_BUSY] = busy;
        word_now[WORD_W - 1 - SW_BNR]  = busy | ~card_ready;
    end

    always_comb begin
        d    = q;
        d.rv = sense;
        if (sense) begin
            d.rw = word_now;
            if (clr_irq) begin
                d.irq = 1'b0;
            end
        end
        // a completion on the same edge wins over the clear
        if (done) begin
            d.last = done_last;
            if (!done_load) begin
                d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{irq: 1'b0, last: 1'b0, rv: 1'b0, rw: '0};
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rv;
    assign rsp_dsw   = q.rw;
    assign irq       = q.irq;

endmodule

// File: rtl/card_reader_emu.sv
module card_reader_emu
    import crd_pkg::*;
#(
    parameter int COLS    = 80,
    parameter int COL_W   = 12,
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int PLEN_W  = 8,
    parameter int GAP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_clr_irq,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              card_ready,
    input  logic [PLEN_W-1:0] cfg_pulse_len,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_dsw,
    output logic              irq,
    input  logic              col_valid,
    input  logic [COL_W-1:0]  col_data,
    input  logic              col_last,
    output logic              col_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              con_stop,
    output logic              con_reset,
    output logic              con_start
);
    localparam int N_STEP = 3;

    logic busy, done, done_load, done_last, seq_active;
    logic is_xfer, start, sense;
    logic [N_STEP-1:0] lines;

    assign is_xfer = cmd_valid && ((cmd_op == OP_READ) || (cmd_op == OP_LOAD));
    assign start   = is_xfer && !busy && !seq_active && card_ready;
    assign sense   = cmd_valid && (cmd_op == OP_SENSE);

    crd_xfer #(
        .COLS(COLS), .COL_W(COL_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LOAD_HI(4)
    ) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_load(cmd_op == OP_LOAD), .start_addr(cmd_addr),
        .col_valid(col_valid), .col_data(col_data), .col_last(col_last),
        .col_ready(col_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready),
        .busy(busy), .done(done), .done_load(done_load), .done_last(done_last)
    );

    crd_status #(.WORD_W(WORD_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .sense(sense), .clr_irq(cmd_clr_irq),
        .done(done), .done_load(done_load), .done_last(done_last),
        .busy(busy), .card_ready(card_ready),
        .rsp_valid(rsp_valid), .rsp_dsw(rsp_dsw), .irq(irq)
    );

    crd_seq #(.PLEN_W(PLEN_W), .GAP_CYC(GAP_CYC), .N_STEP(N_STEP)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .trig(done && done_load), .pulse_len(cfg_pulse_len),
        .active(seq_active), .lines(lines)
    );

    assign con_stop  = lines[0];
    assign con_reset = lines[1];
    assign con_start = lines[2];

endmodule

// File: rtl/crd_checker.sv
module crd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        rsp_valid,
    input logic [15:0] rsp_dsw,
    input logic        irq,
    input logic        col_valid,
    input logic        col_ready,
    input logic        mem_valid,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_data,
    input logic        mem_ready,
    input logic        con_stop,
    input logic        con_reset,
    input logic        con_start,
    input logic        busy,
    input logic        done,
    input logic        done_load,
    input logic        seq_active
);
    logic [1:0] last_kind;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_kind <= 2'd0;
        end else if (con_stop) begin
            last_kind <= 2'd1;
        end else if (con_reset) begin
            last_kind <= 2'd2;
        end else if (con_start) begin
            last_kind <= 2'd3;
        end
    end

    assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    assert_col_to_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && col_ready |=> mem_valid && !col_ready);

    assert_irq_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_load |=> irq && !busy);

    assert_bnr_covers_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_dsw[1] |-> rsp_dsw[0]);

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && cmd_valid && (cmd_op == 2'd1) |=> busy);

    assert_load_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_load && !irq |=> !irq && seq_active);

    assert_console_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({con_stop, con_reset, con_start}));

    assert_reset_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(con_reset) |-> last_kind == 2'd1);

    assert_start_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(con_start) |-> last_kind == 2'd2);

endmodule

bind card_reader_emu crd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_dsw(rsp_dsw), .irq(irq),
    .col_valid(col_valid), .col_ready(col_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready),
    .con_stop(con_stop), .con_reset(con_reset), .con_start(con_start),
    .busy(busy), .done(done), .done_load(done_load), .seq_active(seq_active)
);

// File: tb/card_reader_emu_tb.sv
module card_reader_emu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_clr_irq = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic        card_ready = 1'b1;
    logic [7:0]  cfg_pulse_len = 8'd3;
    logic        rsp_valid, irq, col_ready, mem_valid;
    logic [15:0] rsp_dsw, mem_addr, mem_data;
    logic        col_valid = 1'b0;
    logic [11:0] col_data = '0;
    logic        col_last = 1'b0;
    logic        mem_ready = 1'b0;
    logic        con_stop, con_reset, con_start;

    int n_chk = 0;
    int n_fail = 0;
    logic        force_rdy = 1'b0;
    logic        rdy_val = 1'b0;
    logic [15:0] mem [0:511];
    logic [11:0] card [0:79];
    int ev_n = 0;
    int ev_kind [0:7];
    int ev_w [0:7];
    int ev_gap [0:7];

    always #4 clk = ~clk;

    card_reader_emu u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_clr_irq(cmd_clr_irq), .cmd_addr(cmd_addr), .card_ready(card_ready),
        .cfg_pulse_len(cfg_pulse_len), .rsp_valid(rsp_valid), .rsp_dsw(rsp_dsw),
        .irq(irq), .col_valid(col_valid), .col_data(col_data), .col_last(col_last),
        .col_ready(col_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ready(mem_ready), .con_stop(con_stop),
        .con_reset(con_reset), .con_start(con_start)
    );

    function automatic logic [15:0] norm_word(input logic [11:0] c);
        return {c, 4'b0000};
    endfunction

    function automatic logic [15:0] load_word(input logic [11:0] c);
        return {c[11:8], 4'b0000, c[7:0]};
    endfunction

    function automatic logic [15:0] exp_dsw(input logic i, input logic l, input logic b,
                                            input logic avail);
        logic [15:0] w;
        w = '0;
        w[15 - 0]  = i;
        w[15 - 3]  = l;
        w[15 - 14] = b;
        w[15 - 15] = b | ~avail;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model and ready generator
    always @(posedge clk) if (mem_valid && mem_ready) mem[mem_addr[8:0]] <= mem_data;

    initial begin
        forever begin
            @(negedge clk);
            #1;
            mem_ready = force_rdy ? rdy_val : (($urandom % 4) != 0);
        end
    end

    // console pulse monitor
    initial begin
        int run, idle, kind;
        run = 0; idle = 0; kind = 0;
        forever begin
            @(negedge clk);
            if (con_stop || con_reset || con_start) begin
                if (run == 0 && ev_n < 8) ev_gap[ev_n] = idle;
                kind = con_stop ? 1 : (con_reset ? 2 : 3);
                run++;
                idle = 0;
            end else begin
                if (run != 0 && ev_n < 8) begin
                    ev_kind[ev_n] = kind;
                    ev_w[ev_n] = run;
                    ev_n++;
                end
                run = 0;
                idle++;
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic clr, input logic [15:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_clr_irq = clr; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_clr_irq = 1'b0;
    endtask

    task automatic sense(input logic clr, output logic [15:0] w, output logic v);
        issue(2'd0, clr, 16'h0);
        w = rsp_dsw;
        v = rsp_valid;
    endtask

    task automatic make_card();
        for (int i = 0; i < 80; i++) card[i] = 12'($urandom);
    endtask

    task automatic feed(input logic last);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            col_valid = 1'b0;
            if (($urandom % 3) == 0) @(negedge clk);
            col_valid = 1'b1;
            col_data = card[i];
            col_last = last;
            while (!col_ready) @(negedge clk);
        end
        @(negedge clk);
        col_valid = 1'b0;
    endtask

    task automatic wait_irq();
        int n;
        n = 0;
        while (!irq && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic do_read(input logic [15:0] base, input logic last);
        make_card();
        issue(2'd1, 1'b0, base);
        feed(last);
        wait_irq();
    endtask

    task automatic chk_card(input string req, input logic [15:0] base, input logic ld);
        int bad;
        logic [15:0] e, a;
        bad = 0; a = '0; e = '0;
        for (int i = 0; i < 80; i++) begin
            logic [15:0] x;
            x = ld ? load_word(card[i]) : norm_word(card[i]);
            if (mem[(base + 16'(i)) & 16'h1ff] !== x && bad == 0) begin
                a = mem[(base + 16'(i)) & 16'h1ff];
                e = x;
                bad = 1;
            end
        end
        chk(req, a, e, "card words in memory");
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic v;
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) mem[i] = 16'hdead;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {irq, rsp_valid, col_ready, mem_valid, con_stop, con_reset, con_start},
            32'd0, "outputs after reset");

        // R2 / R5 sense after reset
        sense(1'b0, w, v);
        chk("R2", v, 1, "rsp_valid after sense");
        chk("R2", w, exp_dsw(0, 0, 0, 1), "idle dsw with card");
        card_ready = 1'b0;
        sense(1'b0, w, v);
        chk("R5", w, exp_dsw(0, 0, 0, 0), "idle dsw without card");

        // R8 read with no card is ignored
        issue(2'd1, 1'b0, 16'd300);
        repeat (5) @(negedge clk);
        chk("R8", col_ready, 0, "no transfer without card");
        sense(1'b0, w, v);
        chk("R8", w, exp_dsw(0, 0, 0, 0), "still idle without card");
        card_ready = 1'b1;

        // R3 / R6 read of a last card, random base
        begin
            logic [15:0] base;
            base = 16'(100 + ($urandom % 200));
            make_card();
            issue(2'd1, 1'b0, base);
            fork
                feed(1'b1);
                begin
                    repeat (4) @(negedge clk);
                    sense(1'b0, w, v);
                    chk("R5", w[1:0], 2'b11, "busy sets bits 14 and 15");
                    issue(2'd1, 1'b0, 16'd450); // R8 ignored while busy
                end
            join
            wait_irq();
            chk("R4", irq, 1, "irq after read");
            chk_card("R3", base, 1'b0);
            chk("R8", mem[450], 16'hdead, "read during busy wrote nothing");
            card_ready = 1'b0;
            sense(1'b0, w, v);
            chk("R4", w, exp_dsw(1, 1, 0, 0), "only bit 15 after read, no card");
            chk("R6", w[12], 1, "last-card bit set");
            // R7 clear
            sense(1'b1, w, v);
            chk("R7", irq, 0, "irq cleared by sense");
            sense(1'b0, w, v);
            chk("R7", w, exp_dsw(0, 1, 0, 0), "status kept after clear");
            card_ready = 1'b1;
        end

        // R3 / R6 second read, not last card
        do_read(16'd20, 1'b0);
        chk_card("R3", 16'd20, 1'b0);
        sense(1'b1, w, v);
        chk("R6", w, exp_dsw(1, 0, 0, 1), "last-card bit cleared");

        // R11 collision of completion and clearing sense
        make_card();
        issue(2'd1, 1'b0, 16'd200);
        fork
            feed(1'b0);
            begin
                int n;
                n = 0;
                while (!(mem_valid && mem_addr == 16'd279) && n < 3000) begin
                    @(negedge clk); n++;
                end
                force_rdy = 1'b1; rdy_val = 1'b1;
                cmd_valid = 1'b1; cmd_op = 2'd0; cmd_clr_irq = 1'b1;
                @(negedge clk);
                rdy_val = 1'b0; cmd_valid = 1'b0; cmd_clr_irq = 1'b0;
                chk("R11", rsp_dsw, exp_dsw(0, 0, 1, 1), "word sensed on completion edge");
                chk("R11", irq, 1, "irq survives same-cycle clear");
                force_rdy = 1'b0;
            end
        join
        sense(1'b0, w, v);
        chk("R4", w, exp_dsw(1, 0, 0, 1), "busy gone, irq pending after completion");
        sense(1'b1, w, v);
        chk_card("R3", 16'd200, 1'b0);

        // R9 / R10 program load, random pulse width and zero width
        for (int k = 0; k < 2; k++) begin
            int plen;
            plen = (k == 0) ? (1 + int'($urandom % 6)) : 0;
            cfg_pulse_len = 8'(plen);
            ev_n = 0;
            make_card();
            issue(2'd2, 1'b0, 16'd333);
            feed(1'b1);
            begin
                int n;
                n = 0;
                while (ev_n < 3 && n < 500) begin @(negedge clk); n++; end
            end
            repeat (40) @(negedge clk);
            chk_card("R9", 16'd0, 1'b1);
            chk("R9", irq, 0, "no irq after load");
            chk("R10", ev_n, 3, "pulse count");
            chk("R10", {ev_kind[0][1:0], ev_kind[1][1:0], ev_kind[2][1:0]}, 6'b01_10_11,
                "pulse order");
            chk("R10", {ev_w[0], ev_w[1], ev_w[2]},
                {(plen == 0) ? 1 : plen, (plen == 0) ? 1 : plen, (plen == 0) ? 1 : plen},
                "pulse widths");
            chk("R10", {ev_gap[1], ev_gap[2]}, {32'd4, 32'd4}, "gaps");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule